// File: doc/BRIEF.md
# SIMD Group Issue Scheduler

This block decides, on every clock, which of several SIMD groups owns a shared fetch/decode unit and ALU array. Each group keeps its full execution context in storage of its own. Switching groups therefore costs nothing beyond the choice itself. When the group that is issuing reaches a long-latency memory access, it is parked and another ready group takes the array at the same clock edge. The parked group becomes eligible again once its memory data returns, and it later resumes where it stopped. A single group finishes later this way, but the array is kept busy across groups.

The scheduler sees four kinds of event for each group: launch, stall request, memory return and completion. It reports the group that issues, a valid flag for that issue, the state of every group and a count of the cycles in which nothing issued. Each group runs its own state machine with five states: IDLE (no work), READY (runnable, waiting for the array), ACTIVE (issuing), WAIT (stalled on memory) and FINISHED (done). The transitions are:
- *launch*: IDLE or FINISHED to READY.
- *grant*: READY to ACTIVE.
- *park*: ACTIVE to WAIT.
- *retire*: ACTIVE to FINISHED.
- *wake*: WAIT to READY.

A round-robin picker produces the grant. The picker only acts when no group will be ACTIVE after the current edge.

Top module: `simd_group_sched`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every group is IDLE, `issue_valid_o` is 0 and `idle_cycles_o` is 0.
- R2: Each group's state appears in `grp_state_o[3g+2:3g]` with the codes IDLE=0, READY=1, ACTIVE=2, WAIT=3 and FINISHED=4. A launch moves a group from IDLE or FINISHED to READY one cycle later. A launch is ignored in every other state.
- R3: At most one group is ACTIVE at any time. `issue_valid_o` is 1 exactly when a group is ACTIVE, and `issue_gid_o` then gives the index of that group.
- R4: An ACTIVE group keeps issuing until it receives a stall request or a completion; nothing preempts it. A stall request or completion that arrives for a group that is not ACTIVE is ignored.
- R5: A stall request to the ACTIVE group moves it to WAIT one cycle later. A completion moves it to FINISHED instead. If both arrive in the same cycle, the completion wins.
- R6: A memory return to a group in WAIT moves it to READY one cycle later. A memory return to a group in any other state is ignored.
- R7: At an edge where no group stays ACTIVE, the first READY group is granted and becomes ACTIVE at that same edge, so a switch leaves no gap. The search starts from the group after the last one granted and wraps upward. After reset it starts at group 0. Only groups that were already READY before the edge are considered.
- R8: A stall request to one group and a memory return to another group in the same cycle both take effect at the same edge.
- R9: `idle_cycles_o` goes up by one, modulo 2^CNT_W, at every edge where `issue_valid_o` was 0 before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| grp_start_i | input | NUM_GRP | Launch event, one bit per group |
| grp_stall_i | input | NUM_GRP | Long-latency stall request, one bit per group |
| grp_mret_i | input | NUM_GRP | Memory data returned, one bit per group |
| grp_finish_i | input | NUM_GRP | Completion event, one bit per group |
| issue_valid_o | output | 1 | A group issues this cycle |
| issue_gid_o | output | GID_W | Index of the issuing group |
| grp_state_o | output | 3*NUM_GRP | Packed state codes, three bits per group |
| idle_cycles_o | output | CNT_W | Count of cycles with no issue |

## Verification
Every event is sampled at a rising edge, and its effect on the group states and on the issue outputs appears right after that same edge. The idle count reflects the valid flag from the cycle before the edge. The bench drives events on the falling edge. It advances a reference model of the requirements once per rising edge, then compares all outputs at the following falling edge, exactly one edge after the stimulus. A newly woken or launched group is READY one edge after its event and can be granted no earlier than the edge after that; the model follows the same timing.

// File: rtl/simd_sched_pkg.sv
package simd_sched_pkg;

    typedef enum logic [2:0] {
        GS_IDLE     = 3'd0,
        GS_READY    = 3'd1,
        GS_ACTIVE   = 3'd2,
        GS_WAIT     = 3'd3,
        GS_FINISHED = 3'd4
    } grp_state_e;

    localparam int unsigned STATE_W = 3;

endpackage

// File: rtl/sched_grp_fsm.sv
module sched_grp_fsm
    import simd_sched_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       start_i,
    input  logic       stall_i,
    input  logic       ret_i,
    input  logic       finish_i,
    input  logic       grant_i,
    output grp_state_e state_o
);

    grp_state_e state_q;
    grp_state_e state_d;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= GS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: launch, grant, park, retire, wake
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_IDLE: begin
                if (start_i) state_d = GS_READY;
            end
            GS_READY: begin
                if (grant_i) state_d = GS_ACTIVE;
            end
            GS_ACTIVE: begin
                if (finish_i) begin
                    state_d = GS_FINISHED;
                end else if (stall_i) begin
                    state_d = GS_WAIT;
                end
            end
            GS_WAIT: begin
                if (ret_i) state_d = GS_READY;
            end
            GS_FINISHED: begin
                if (start_i) state_d = GS_READY;
            end
            default: begin
                state_d = GS_IDLE;
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/sched_rr_pick.sv
module sched_rr_pick #(
    parameter int unsigned NUM_GRP = 4,
    parameter int unsigned IDX_W   = 2
) (
    input  logic [NUM_GRP-1:0] req_i,
    input  logic [IDX_W-1:0]   last_i,
    output logic [NUM_GRP-1:0] gnt_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic               any_o
);

    // scan upward starting one past the last grant, wrapping around
    always_comb begin
        logic found;
        found = 1'b0;
        gnt_o = '0;
        idx_o = '0;
        for (int k = 1; k <= int'(NUM_GRP); k++) begin
            int c;
            c = (int'(last_i) + k) % int'(NUM_GRP);
            if (!found && req_i[c]) begin
                found    = 1'b1;
                gnt_o[c] = 1'b1;
                idx_o    = c[IDX_W-1:0];
            end
        end
        any_o = found;
    end

endmodule

// File: rtl/sched_idle_ctr.sv
module sched_idle_ctr #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             busy_i,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (!busy_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/simd_group_sched.sv
module simd_group_sched
    import simd_sched_pkg::*;
#(
    parameter int unsigned NUM_GRP = 4,
    parameter int unsigned CNT_W   = 16,
    localparam int unsigned GID_W  = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [NUM_GRP-1:0]         grp_start_i,
    input  logic [NUM_GRP-1:0]         grp_stall_i,
    input  logic [NUM_GRP-1:0]         grp_mret_i,
    input  logic [NUM_GRP-1:0]         grp_finish_i,
    output logic                       issue_valid_o,
    output logic [GID_W-1:0]           issue_gid_o,
    output logic [STATE_W*NUM_GRP-1:0] grp_state_o,
    output logic [CNT_W-1:0]           idle_cycles_o
);

    localparam logic [GID_W-1:0] LAST_INIT = GID_W'(NUM_GRP - 1);

    grp_state_e         st [NUM_GRP];
    logic [NUM_GRP-1:0] active_v;
    logic [NUM_GRP-1:0] ready_v;
    logic [NUM_GRP-1:0] pick_gnt;
    logic [NUM_GRP-1:0] grant_v;
    logic [GID_W-1:0]   pick_idx;
    logic               pick_any;
    logic               keep_run;
    logic [GID_W-1:0]   last_q;

    // one state machine per group, each with its own context slot
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        sched_grp_fsm u_fsm (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .start_i  (grp_start_i[g]),
            .stall_i  (grp_stall_i[g]),
            .ret_i    (grp_mret_i[g]),
            .finish_i (grp_finish_i[g]),
            .grant_i  (grant_v[g]),
            .state_o  (st[g])
        );
        assign active_v[g] = (st[g] == GS_ACTIVE);
        assign ready_v[g]  = (st[g] == GS_READY);
    end

    sched_rr_pick #(
        .NUM_GRP (NUM_GRP),
        .IDX_W   (GID_W)
    ) u_pick (
        .req_i  (ready_v),
        .last_i (last_q),
        .gnt_o  (pick_gnt),
        .idx_o  (pick_idx),
        .any_o  (pick_any)
    );

    // the active group stays unless it is parked or retired this cycle
    assign keep_run = |(active_v & ~grp_stall_i & ~grp_finish_i);
    assign grant_v  = keep_run ? '0 : pick_gnt;

    // round-robin pointer register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            last_q <= LAST_INIT;
        end else if (!keep_run && pick_any) begin
            last_q <= pick_idx;
        end
    end

    sched_idle_ctr #(
        .CNT_W (CNT_W)
    ) u_idle (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .busy_i (issue_valid_o),
        .cnt_o  (idle_cycles_o)
    );

    // outputs
    always_comb begin
        issue_valid_o = |active_v;
        issue_gid_o   = '0;
        for (int g = 0; g < int'(NUM_GRP); g++) begin
            if (active_v[g]) issue_gid_o = GID_W'(g);
            grp_state_o[STATE_W*g +: STATE_W] = st[g];
        end
    end

endmodule

// File: rtl/sched_chk.sv
module sched_chk #(
    parameter int unsigned NUM_GRP = 4,
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned GID_W   = 2
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic [NUM_GRP-1:0]   grp_start_i,
    input logic [NUM_GRP-1:0]   grp_stall_i,
    input logic [NUM_GRP-1:0]   grp_mret_i,
    input logic [NUM_GRP-1:0]   grp_finish_i,
    input logic                 issue_valid_o,
    input logic [GID_W-1:0]     issue_gid_o,
    input logic [3*NUM_GRP-1:0] grp_state_o,
    input logic [CNT_W-1:0]     idle_cycles_o
);

    logic [NUM_GRP-1:0] act_v;
    logic [NUM_GRP-1:0] rdy_v;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
        assign act_v[g] = (grp_state_o[3*g +: 3] == 3'd2);
        assign rdy_v[g] = (grp_state_o[3*g +: 3] == 3'd1);

        a_r2_launch_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ((grp_state_o[3*g +: 3] == 3'd0 || grp_state_o[3*g +: 3] == 3'd4) && grp_start_i[g])
            |=> (grp_state_o[3*g +: 3] == 3'd1));

        a_r5_park_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (grp_state_o[3*g +: 3] == 3'd2 && grp_stall_i[g] && !grp_finish_i[g])
            |=> (grp_state_o[3*g +: 3] == 3'd3));

        a_r5_retire_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (grp_state_o[3*g +: 3] == 3'd2 && grp_finish_i[g])
            |=> (grp_state_o[3*g +: 3] == 3'd4));

        a_r6_wake_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (grp_state_o[3*g +: 3] == 3'd3 && grp_mret_i[g])
            |=> (grp_state_o[3*g +: 3] == 3'd1));
    end

    a_r3_single_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($countones(act_v) <= 1) && (issue_valid_o == (act_v != '0)));

    a_r4_no_preempt: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (issue_valid_o && !grp_stall_i[issue_gid_o] && !grp_finish_i[issue_gid_o])
        |=> (issue_valid_o && issue_gid_o == $past(issue_gid_o)));

    a_r7_no_bubble: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (issue_valid_o && (grp_stall_i[issue_gid_o] || grp_finish_i[issue_gid_o]) && (rdy_v != '0))
        |=> issue_valid_o);

    a_r9_idle_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !issue_valid_o |=> (idle_cycles_o == CNT_W'($past(idle_cycles_o) + 1'b1)));

endmodule

bind simd_group_sched sched_chk #(
    .NUM_GRP (NUM_GRP),
    .CNT_W   (CNT_W),
    .GID_W   (GID_W)
) chk_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .grp_start_i   (grp_start_i),
    .grp_stall_i   (grp_stall_i),
    .grp_mret_i    (grp_mret_i),
    .grp_finish_i  (grp_finish_i),
    .issue_valid_o (issue_valid_o),
    .issue_gid_o   (issue_gid_o),
    .grp_state_o   (grp_state_o),
    .idle_cycles_o (idle_cycles_o)
);

// File: tb/simd_group_sched_tb.sv
`timescale 1ns/1ps
module simd_group_sched_tb_top;

    localparam int N     = 4;
    localparam int CW    = 16;
    localparam int GW    = 2;
    localparam int LIMIT = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  start_v = '0, stall_v = '0, ret_v = '0, fin_v = '0;
    logic          vld;
    logic [GW-1:0] gid;
    logic [3*N-1:0] st_o;
    logic [CW-1:0] idle_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    int mst [N];
    int mlast;
    int mcnt;

    always #2 clk = ~clk;

    simd_group_sched #(.NUM_GRP(N), .CNT_W(CW)) dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .grp_start_i   (start_v),
        .grp_stall_i   (stall_v),
        .grp_mret_i    (ret_v),
        .grp_finish_i  (fin_v),
        .issue_valid_o (vld),
        .issue_gid_o   (gid),
        .grp_state_o   (st_o),
        .idle_cycles_o (idle_o)
    );

    function automatic int model_active();
        for (int g = 0; g < N; g++) if (mst[g] == 2) return g;
        return -1;
    endfunction

    // reference update for one rising edge, from the requirements
    task automatic model_step(input logic [N-1:0] s, input logic [N-1:0] p,
                              input logic [N-1:0] r, input logic [N-1:0] f);
        int nst [N];
        int pick;
        bit keep;
        keep = 1'b0;
        pick = -1;
        if (model_active() < 0) mcnt = (mcnt + 1) % (1 << CW);
        for (int g = 0; g < N; g++) if (mst[g] == 2 && !p[g] && !f[g]) keep = 1'b1;
        if (!keep) begin
            for (int k = 1; k <= N; k++) begin
                int c;
                c = (mlast + k) % N;
                if (pick < 0 && mst[c] == 1) pick = c;
            end
        end
        for (int g = 0; g < N; g++) begin
            nst[g] = mst[g];
            case (mst[g])
                0, 4: if (s[g]) nst[g] = 1;
                1: if (g == pick) nst[g] = 2;
                2: if (f[g]) nst[g] = 4; else if (p[g]) nst[g] = 3;
                3: if (r[g]) nst[g] = 1;
                default: nst[g] = 0;
            endcase
        end
        if (pick >= 0) mlast = pick;
        for (int g = 0; g < N; g++) mst[g] = nst[g];
    endtask

    task automatic compare(input string tag);
        int ea;
        ea = model_active();
        for (int g = 0; g < N; g++) begin
            total++;
            if (int'(st_o[3*g +: 3]) != mst[g]) begin
                bad++;
                $display("FAIL %s group %0d state actual=%0d expected=%0d", tag, g, st_o[3*g +: 3], mst[g]);
            end
        end
        total++;
        if (vld != (ea >= 0)) begin
            bad++;
            $display("FAIL R3 (%s) issue_valid actual=%0d expected=%0d", tag, vld, (ea >= 0));
        end
        if (ea >= 0) begin
            total++;
            if (int'(gid) != ea) begin
                bad++;
                $display("FAIL R7 (%s) issue_gid actual=%0d expected=%0d", tag, gid, ea);
            end
        end
        total++;
        if (int'(idle_o) != mcnt) begin
            bad++;
            $display("FAIL R9 (%s) idle_cycles actual=%0d expected=%0d", tag, idle_o, mcnt);
        end
    endtask

    // drive on a falling edge, let one rising edge pass, compare on the next falling edge
    task automatic step(input logic [N-1:0] s, input logic [N-1:0] p,
                        input logic [N-1:0] r, input logic [N-1:0] f, input string tag);
        start_v = s; stall_v = p; ret_v = r; fin_v = f;
        @(posedge clk);
        model_step(s, p, r, f);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int g = 0; g < N; g++) mst[g] = 0;
        mlast = N - 1;
        mcnt  = 0;
        repeat (3) @(negedge clk);
        compare("R1 in reset");
        rst_n = 1'b1;
        compare("R1 after release");

        // R9: nothing launched, counter climbs
        step('0, '0, '0, '0, "R9 idle");
        step('0, '0, '0, '0, "R9 idle");
        // R2: launch groups 0..2 together
        step(4'b0111, '0, '0, '0, "R2 launch");
        // R7: group 0 is granted first after reset
        step('0, '0, '0, '0, "R7 first grant");
        // R4/R6: stall to non-active group 2 and return to ready group 1 are ignored
        step('0, 4'b0100, 4'b0010, 4'b1000, "R4 R6 ignored");
        // R5/R7: park group 0, group 1 takes over at the same edge
        step('0, 4'b0001, '0, '0, "R5 park R7 switch");
        // R8: park group 1 while group 0 wakes
        step('0, 4'b0010, 4'b0001, '0, "R8 concurrent");
        // R5: finish wins over stall on group 2
        step('0, 4'b0100, '0, 4'b0100, "R5 finish priority");
        // R2: relaunch finished group 2, launch on active group 0 ignored
        step(4'b0101, '0, '0, '0, "R2 relaunch");
        step('0, '0, 4'b0010, '0, "R6 wake");
        step('0, 4'b0001, '0, '0, "R7 wrap order");
        step('0, '0, '0, '0, "R4 keep");

        // constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [N-1:0] s, p, r, f;
            for (int g = 0; g < N; g++) begin
                s[g] = ($urandom % 10) == 0;
                p[g] = (mst[g] == 2) ? (($urandom % 4) == 0) : (($urandom % 12) == 0);
                r[g] = ($urandom % 3) == 0;
                f[g] = ($urandom % 16) == 0;
            end
            step(s, p, r, f, "R7 random");
        end

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule